// File: doc/BRIEF.md
# Secure Second-Stage Translation Control Register

This block holds the 64-bit control word for a secure second-stage address translation. Software reaches it through a single-request system-register port. Each request carries the current exception level, the security state, a three-bit nested-virtualization control vector and an enable bit from the highest level. The block decides the fate of every request in a small access state machine. A request can complete as a read, complete as a write, get an undefined-instruction response, trap to the hypervisor level with a fixed syndrome class, or be redirected to a fixed memory offset. Only a completed write changes the stored word.

From the stored word and a large-descriptor mode input, the block also drives the effective translation configuration continuously. This configuration is the output address space, the table-walk address space, the granule size, the initial lookup level and a level-0 translation fault flag. The effective values can differ from the stored word. A set walk-space bit forces the output space to non-secure. A reserved granule code acts as 4KB. A start level that does not fit the region size raises the fault flag.

The access state machine has three states. `ST_IDLE` accepts a request and moves to `ST_CHECK` (transition *accept*). `ST_CHECK` applies the access decision, commits a permitted write and moves to `ST_RESP` (transition *decide*). `ST_RESP` presents the response for one cycle and returns to `ST_IDLE` (transition *release*).

Top module: `sxc_ctrl_top`

## Requirements
- R1: After reset, a completed read returns 64'h0000_0000_8000_0000. The only set bit is the always-one bit 31.
- R2: A completed write stores only these fields: start-level extension bit 33, output-space bit 30, walk-space bit 29, granule code bits 15:14, start-level code bits 7:6 and region-size offset bits 5:0. Every other bit reads 0, except bit 31, which always reads 1.
- R3: When bit 29 is 1, `eff_out_ns` is 1 whatever bit 30 holds, and a read still returns the stored bit 30. When bit 29 is 0, `eff_out_ns` follows bit 30. `eff_walk_ns` follows bit 29.
- R4: The granule code is 00 for 4KB, 01 for 64KB and 10 for 16KB. A stored 11 drives `eff_gran` = 00 and acts as 4KB everywhere, while a read returns 11.
- R5: With `ds_mode`=0, start-level codes 00, 01 and 10 give levels 2, 1 and 0 for 4KB, and levels 3, 2 and 1 for 16KB and 64KB. Code 11 sets `eff_fault`.
- R6: With `ds_mode`=1 and a 4KB granule, the extension bit joins the start-level code. Combined values 0_00, 0_01, 0_10 and 0_11 give levels 2, 1, 0 and 3. Combined value 1_00 gives level -1, encoded 3'b111. Other combined values set `eff_fault`. With `ds_mode`=1 and a 16KB granule, code 11 gives level 0. In all other cases the extension bit has no effect.
- R7: Let B = 64 - offset be the region width in bits, p and s the page-offset and per-level bits (12/9, 14/11 and 16/13 for 4KB, 16KB and 64KB), and W = p + s*(4 - level). `eff_fault` is 1 unless W - s < B <= W + 4.
- R8: Every request at level 0 gets an undefined response (`rsp_kind`=2). So does a request at level 1 or 2 with `req_secure`=0, and a request at level 3 with `req_eel2`=0. Secure level 2 and enabled level 3 complete: `rsp_kind`=0 for a read, 1 for a write.
- R9: At secure level 1, a control vector with bits 2 and 0 both set redirects the access: `rsp_kind`=4 and `rsp_offset`=12'h048.
- R10: At secure level 1, a control vector with bit 0 set and bit 2 clear traps: `rsp_kind`=3 and `rsp_ec`=6'h18. A vector with bit 0 clear gets an undefined response.
- R11: A request that does not complete as a write leaves the stored word unchanged.
- R12: `req_ready` is 1 only in `ST_IDLE`. The response is valid for exactly one cycle, two clock edges after the request is accepted. `rsp_rdata` is 0 for every outcome except a completed read, `rsp_ec` is 0 except on a trap, and `rsp_offset` is 0 except on a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| req_el | input | 2 | Requesting exception level |
| req_secure | input | 1 | Requester is in the secure state |
| req_nv | input | 3 | Nested-virtualization control vector |
| req_eel2 | input | 1 | Enable from the highest level for secure level 2 |
| ds_mode | input | 1 | Large-descriptor mode |
| rsp_valid | output | 1 | Response strobe |
| rsp_kind | output | 3 | Outcome: 0 read done, 1 write done, 2 undefined, 3 trap, 4 redirect |
| rsp_rdata | output | 64 | Read data |
| rsp_ec | output | 6 | Trap syndrome class |
| rsp_offset | output | 12 | Redirect memory offset |
| eff_out_ns | output | 1 | Effective output address space is non-secure |
| eff_walk_ns | output | 1 | Effective walk address space is non-secure |
| eff_gran | output | 2 | Effective granule code |
| eff_level | output | 3 | Effective initial lookup level, two's complement |
| eff_fault | output | 1 | Level-0 translation fault indication |

## Verification
The assertions check, on every cycle, properties that hold in any sequence of requests. The always-one and always-zero bits hold in every completed read. The granule output never shows the reserved code. The walk-space bit always forces the output space. Level-0 requests never complete, and a trap always carries its syndrome class. The stored word changes only through a completed write, and each response lasts one cycle. The bench scenarios are needed to show the exact level table under both descriptor modes, the region-width consistency windows, the full privilege and virtualization matrix, and that refused writes are invisible on a later read.

// File: rtl/sxc_pkg.sv
package sxc_pkg;

    localparam int REG_W      = 64;
    localparam int POS_EXT    = 33;
    localparam int POS_ONE    = 31;
    localparam int POS_OUTNS  = 30;
    localparam int POS_WALKNS = 29;
    localparam int POS_GR_LO  = 14;
    localparam int POS_SL_LO  = 6;
    localparam int OFS_W      = 6;
    localparam int EC_W       = 6;
    localparam int OFF_W      = 12;

    localparam logic [REG_W-1:0] ONE_MASK = REG_W'(1) << POS_ONE;
    localparam logic [REG_W-1:0] WR_MASK  =
        (REG_W'(1) << POS_EXT) | (REG_W'(1) << POS_OUTNS) |
        (REG_W'(1) << POS_WALKNS) | (REG_W'(3) << POS_GR_LO) |
        (REG_W'(3) << POS_SL_LO) | REG_W'((1 << OFS_W) - 1);
    localparam logic [REG_W-1:0] RST_VAL  = ONE_MASK;

    typedef enum logic [2:0] {
        OUT_RD_DONE = 3'd0,
        OUT_WR_DONE = 3'd1,
        OUT_UNDEF   = 3'd2,
        OUT_TRAP    = 3'd3,
        OUT_REDIR   = 3'd4
    } outcome_e;

    typedef enum logic [1:0] {
        GR_4K   = 2'b00,
        GR_64K  = 2'b01,
        GR_16K  = 2'b10,
        GR_RSVD = 2'b11
    } gran_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RESP  = 2'd2
    } acc_state_e;

endpackage

// File: rtl/sxc_access_gate.sv
module sxc_access_gate
    import sxc_pkg::*;
(
    input  logic       is_write,
    input  logic [1:0] el,
    input  logic       secure,
    input  logic [2:0] nv,
    input  logic       eel2,
    output outcome_e   outcome
);
    outcome_e done_kind;

    always_comb begin
        done_kind = is_write ? OUT_WR_DONE : OUT_RD_DONE;
        unique case (el)
            2'd0: outcome = OUT_UNDEF;
            2'd1: begin
                if (!secure)             outcome = OUT_UNDEF;
                else if (nv[2] && nv[0]) outcome = OUT_REDIR;
                else if (nv[0])          outcome = OUT_TRAP;
                else                     outcome = OUT_UNDEF;
            end
            2'd2: outcome = secure ? done_kind : OUT_UNDEF;
            2'd3: outcome = eel2 ? done_kind : OUT_UNDEF;
            default: outcome = OUT_UNDEF;
        endcase
    end
endmodule

// File: rtl/sxc_field_eval.sv
module sxc_field_eval
    import sxc_pkg::*;
(
    input  logic [REG_W-1:0] reg_val,
    input  logic             ds,
    output logic             out_ns,
    output logic             walk_ns,
    output logic [1:0]       gran,
    output logic [2:0]       level,
    output logic             fault
);
    logic [1:0] gr_raw;
    logic [1:0] sl_code;
    logic       ext_bit;
    logic [OFS_W-1:0] ofs;
    logic       lvl_rsvd;
    int         lvl_i;
    int         pg_bits;
    int         st_bits;
    int         span;
    int         width;

    assign gr_raw  = reg_val[POS_GR_LO +: 2];
    assign sl_code = reg_val[POS_SL_LO +: 2];
    assign ext_bit = reg_val[POS_EXT];
    assign ofs     = reg_val[OFS_W-1:0];
    assign walk_ns = reg_val[POS_WALKNS];
    assign out_ns  = reg_val[POS_OUTNS] | reg_val[POS_WALKNS];
    assign gran    = (gr_raw == GR_RSVD) ? GR_4K : gr_raw;

    // start level selection
    always_comb begin
        lvl_rsvd = 1'b0;
        lvl_i    = 0;
        if (gran == GR_4K) begin
            unique case ({ds & ext_bit, sl_code})
                3'b000: lvl_i = 2;
                3'b001: lvl_i = 1;
                3'b010: lvl_i = 0;
                3'b011: begin
                    lvl_i    = 3;
                    lvl_rsvd = !ds;
                end
                3'b100: lvl_i = -1;
                default: lvl_rsvd = 1'b1;
            endcase
        end else begin
            unique case (sl_code)
                2'b00: lvl_i = 3;
                2'b01: lvl_i = 2;
                2'b10: lvl_i = 1;
                default: begin
                    lvl_i    = 0;
                    lvl_rsvd = !(ds && gran == GR_16K);
                end
            endcase
        end
    end

    // region width consistency
    always_comb begin
        unique case (gran)
            GR_16K:  begin pg_bits = 14; st_bits = 11; end
            GR_64K:  begin pg_bits = 16; st_bits = 13; end
            default: begin pg_bits = 12; st_bits = 9;  end
        endcase
        width = 64 - int'(ofs);
        span  = pg_bits + st_bits * (4 - lvl_i);
        fault = lvl_rsvd || !((width > span - st_bits) && (width <= span + 4));
    end

    assign level = lvl_rsvd ? 3'd0 : 3'(lvl_i);
endmodule

// File: rtl/sxc_ctrl_top.sv
module sxc_ctrl_top
    import sxc_pkg::*;
#(
    parameter logic [OFF_W-1:0] REDIR_OFF = 12'h048,
    parameter logic [EC_W-1:0]  TRAP_EC   = 6'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [REG_W-1:0]  req_wdata,
    input  logic [1:0]        req_el,
    input  logic              req_secure,
    input  logic [2:0]        req_nv,
    input  logic              req_eel2,
    input  logic              ds_mode,
    output logic              rsp_valid,
    output logic [2:0]        rsp_kind,
    output logic [REG_W-1:0]  rsp_rdata,
    output logic [EC_W-1:0]   rsp_ec,
    output logic [OFF_W-1:0]  rsp_offset,
    output logic              eff_out_ns,
    output logic              eff_walk_ns,
    output logic [1:0]        eff_gran,
    output logic [2:0]        eff_level,
    output logic              eff_fault
);
    acc_state_e        state_q, state_d;
    logic              cap_write;
    logic [REG_W-1:0]  cap_wdata;
    logic [1:0]        cap_el;
    logic              cap_secure;
    logic [2:0]        cap_nv;
    logic              cap_eel2;
    logic [REG_W-1:0]  word_q;
    outcome_e          decision;
    outcome_e          kind_q;
    logic [REG_W-1:0]  rdata_q;
    logic [EC_W-1:0]   ec_q;
    logic [OFF_W-1:0]  off_q;

    sxc_access_gate u_gate (
        .is_write (cap_write),
        .el       (cap_el),
        .secure   (cap_secure),
        .nv       (cap_nv),
        .eel2     (cap_eel2),
        .outcome  (decision)
    );

    sxc_field_eval u_eval (
        .reg_val  (word_q),
        .ds       (ds_mode),
        .out_ns   (eff_out_ns),
        .walk_ns  (eff_walk_ns),
        .gran     (eff_gran),
        .level    (eff_level),
        .fault    (eff_fault)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_CHECK;
            ST_CHECK: state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register, capture, storage and response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cap_write  <= 1'b0;
            cap_wdata  <= '0;
            cap_el     <= 2'd0;
            cap_secure <= 1'b0;
            cap_nv     <= 3'd0;
            cap_eel2   <= 1'b0;
            word_q     <= RST_VAL;
            kind_q     <= OUT_UNDEF;
            rdata_q    <= '0;
            ec_q       <= '0;
            off_q      <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                cap_write  <= req_write;
                cap_wdata  <= req_wdata;
                cap_el     <= req_el;
                cap_secure <= req_secure;
                cap_nv     <= req_nv;
                cap_eel2   <= req_eel2;
            end
            if (state_q == ST_CHECK) begin
                kind_q  <= decision;
                rdata_q <= (decision == OUT_RD_DONE) ? word_q : '0;
                ec_q    <= (decision == OUT_TRAP) ? TRAP_EC : '0;
                off_q   <= (decision == OUT_REDIR) ? REDIR_OFF : '0;
                if (decision == OUT_WR_DONE)
                    word_q <= (cap_wdata & WR_MASK) | ONE_MASK;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        rsp_valid  = (state_q == ST_RESP);
        rsp_kind   = kind_q;
        rsp_rdata  = rdata_q;
        rsp_ec     = ec_q;
        rsp_offset = off_q;
    end

    // R1 R2: read data keeps the fixed bits
    p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == OUT_RD_DONE) |->
            (rsp_rdata[POS_ONE] && ((rsp_rdata & ~(WR_MASK | ONE_MASK)) == '0)));

    // R4: reserved granule code never reaches the effective output
    p_gran_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        eff_gran != GR_RSVD);

    // R3: walk space forces output space
    p_walk_forces_r3: assert property (@(posedge clk) disable iff (!rst_n)
        eff_walk_ns |-> eff_out_ns);

    // R8: level 0 never completes
    p_el0_undef_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && cap_el == 2'd0) |-> rsp_kind == OUT_UNDEF);

    // R10: trap carries the syndrome class
    p_trap_ec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == OUT_TRAP) |-> rsp_ec == TRAP_EC);

    // R11: stored word unchanged unless a write completed
    p_word_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind != OUT_WR_DONE) |-> word_q == $past(word_q));

    // R12: response lasts one cycle
    p_one_cycle_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: tb/sxc_ctrl_top_tb.sv
module sxc_ctrl_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  req_el = 2'd0;
    logic        req_secure = 1'b0;
    logic [2:0]  req_nv = 3'd0;
    logic        req_eel2 = 1'b0;
    logic        ds_mode = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_kind;
    logic [63:0] rsp_rdata;
    logic [5:0]  rsp_ec;
    logic [11:0] rsp_offset;
    logic        eff_out_ns, eff_walk_ns, eff_fault;
    logic [1:0]  eff_gran;
    logic [2:0]  eff_level;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [63:0] model_word = 64'h0000_0000_8000_0000;
    logic [2:0]  q_kind[$];
    logic [63:0] q_data[$];
    logic [5:0]  q_ec[$];
    logic [11:0] q_off[$];
    string       q_tag[$];

    localparam logic [63:0] KEEP = 64'h0000_0002_E000_C0FF;

    always #2.5 clk = ~clk;

    sxc_ctrl_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wdata(req_wdata), .req_el(req_el),
        .req_secure(req_secure), .req_nv(req_nv), .req_eel2(req_eel2),
        .ds_mode(ds_mode), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
        .rsp_rdata(rsp_rdata), .rsp_ec(rsp_ec), .rsp_offset(rsp_offset),
        .eff_out_ns(eff_out_ns), .eff_walk_ns(eff_walk_ns), .eff_gran(eff_gran),
        .eff_level(eff_level), .eff_fault(eff_fault)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] want_kind(logic w, logic [1:0] el, logic sec,
                                             logic [2:0] nv, logic en);
        if (el == 2'd0) return 3'd2;
        if (el == 2'd3) return en ? {2'b00, w} : 3'd2;
        if (!sec) return 3'd2;
        if (el == 2'd2) return {2'b00, w};
        if (nv[0] && nv[2]) return 3'd4;
        if (nv[0]) return 3'd3;
        return 3'd2;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_kind.size() == 0) begin
                chk(64'(rsp_kind), 64'h7, "R12 unexpected response");
            end else begin
                logic [2:0] k;
                string t;
                k = q_kind.pop_front();
                t = q_tag.pop_front();
                chk(64'(rsp_kind), 64'(k), t);
                chk(rsp_rdata, q_data.pop_front(), {t, " data R12"});
                chk(64'(rsp_ec), 64'(q_ec.pop_front()), {t, " ec R10"});
                chk(64'(rsp_offset), 64'(q_off.pop_front()), {t, " offset R9"});
            end
        end
    end

    task automatic acc(input logic w, input logic [63:0] d, input logic [1:0] el,
                       input logic sec, input logic [2:0] nv, input logic en,
                       input string tag);
        logic [2:0] k;
        k = want_kind(w, el, sec, nv, en);
        q_kind.push_back(k);
        q_data.push_back(k == 3'd0 ? model_word : 64'h0);
        q_ec.push_back(k == 3'd3 ? 6'h18 : 6'h0);
        q_off.push_back(k == 3'd4 ? 12'h048 : 12'h0);
        q_tag.push_back(tag);
        if (k == 3'd1) model_word = (d & KEEP) | 64'h8000_0000;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_wdata = d; req_el = el;
        req_secure = sec; req_nv = nv; req_eel2 = en;
        @(negedge clk);
        req_valid = 1'b0;
        chk(64'(req_ready), 64'h0, "R12 busy after accept");
        chk(64'(rsp_valid), 64'h0, "R12 no early response");
        @(negedge clk);
        chk(64'(rsp_valid), 64'h1, "R12 response two edges later");
    endtask

    task automatic wr2(input logic [63:0] d, input string tag);
        acc(1'b1, d, 2'd2, 1'b1, 3'd0, 1'b0, tag);
    endtask

    task automatic rd2(input string tag);
        acc(1'b0, 64'h0, 2'd2, 1'b1, 3'd0, 1'b0, tag);
    endtask

    task automatic eff(input logic o, input logic wk, input logic [1:0] g,
                       input logic [2:0] lv, input logic f, input string tag);
        @(negedge clk);
        chk(64'(eff_out_ns), 64'(o), {tag, " out space"});
        chk(64'(eff_walk_ns), 64'(wk), {tag, " walk space"});
        chk(64'(eff_gran), 64'(g), {tag, " granule"});
        chk(64'(eff_fault), 64'(f), {tag, " fault"});
        if (!f) chk(64'(eff_level), 64'(lv), {tag, " level"});
    endtask

    // words: sl2 bit33, outns 30, walkns 29, gran 15:14, sl 7:6, ofs 5:0
    function automatic logic [63:0] mk(logic e, logic o, logic wk, logic [1:0] g,
                                       logic [1:0] s, logic [5:0] z);
        return (64'(e) << 33) | (64'(o) << 30) | (64'(wk) << 29) |
               (64'(g) << 14) | (64'(s) << 6) | 64'(z);
    endfunction

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(64'(req_ready), 64'h1, "R12 ready after reset");
        chk(64'(rsp_valid), 64'h0, "R12 idle after reset");
        rst_n = 1'b1;
        // reset word: 4KB, code 00 -> level 2, width 64 inconsistent
        eff(1'b0, 1'b0, 2'b00, 3'd2, 1'b1, "R1 reset effective");
        rd2("R1 reset read");

        wr2(64'hFFFF_FFFF_FFFF_FFFF, "R2 write all ones");
        rd2("R2 masked readback");
        eff(1'b1, 1'b1, 2'b00, 3'd0, 1'b1, "R4 R5 all ones");
        wr2(64'h0, "R2 write zeros");
        rd2("R2 one bit survives");

        wr2(mk(0, 0, 1, 2'b00, 2'b00, 6'd34), "R3 walk only");
        rd2("R3 readback keeps output bit");
        eff(1'b1, 1'b1, 2'b00, 3'd2, 1'b0, "R3 forced output space");
        wr2(mk(0, 1, 0, 2'b00, 2'b00, 6'd34), "R3 output only");
        eff(1'b1, 1'b0, 2'b00, 3'd2, 1'b0, "R3 output follows");

        wr2(mk(0, 0, 0, 2'b00, 2'b01, 6'd25), "R5 4K code01");
        eff(1'b0, 1'b0, 2'b00, 3'd1, 1'b0, "R5 4K level1");
        wr2(mk(0, 0, 0, 2'b00, 2'b10, 6'd16), "R5 4K code10");
        eff(1'b0, 1'b0, 2'b00, 3'd0, 1'b0, "R5 4K level0");
        wr2(mk(0, 0, 0, 2'b10, 2'b00, 6'd40), "R5 16K code00");
        eff(1'b0, 1'b0, 2'b10, 3'd3, 1'b0, "R5 16K level3");
        wr2(mk(0, 0, 0, 2'b01, 2'b10, 6'd12), "R5 64K code10");
        eff(1'b0, 1'b0, 2'b01, 3'd1, 1'b0, "R5 64K level1");
        wr2(mk(0, 0, 0, 2'b01, 2'b11, 6'd12), "R5 64K code11");
        eff(1'b0, 1'b0, 2'b01, 3'd0, 1'b1, "R5 reserved code fault");
        wr2(mk(1, 0, 0, 2'b00, 2'b00, 6'd8), "R6 ext with ds0");
        eff(1'b0, 1'b0, 2'b00, 3'd2, 1'b1, "R6 ext ignored ds0 R7 too wide");

        ds_mode = 1'b1;
        eff(1'b0, 1'b0, 2'b00, 3'b111, 1'b0, "R6 ds1 level minus1");
        wr2(mk(0, 0, 0, 2'b00, 2'b11, 6'd40), "R6 4K code11");
        eff(1'b0, 1'b0, 2'b00, 3'd3, 1'b0, "R6 ds1 level3");
        wr2(mk(1, 0, 0, 2'b00, 2'b01, 6'd40), "R6 ext code01");
        eff(1'b0, 1'b0, 2'b00, 3'd0, 1'b1, "R6 reserved combination");
        wr2(mk(0, 0, 0, 2'b10, 2'b11, 6'd8), "R6 16K code11");
        eff(1'b0, 1'b0, 2'b10, 3'd0, 1'b0, "R6 16K level0");
        ds_mode = 1'b0;

        wr2(mk(0, 0, 0, 2'b00, 2'b00, 6'd16), "R7 inconsistent width");
        eff(1'b0, 1'b0, 2'b00, 3'd2, 1'b1, "R7 fault");
        wr2(mk(0, 0, 0, 2'b00, 2'b00, 6'd30), "R7 width at W+4");
        eff(1'b0, 1'b0, 2'b00, 3'd2, 1'b0, "R7 upper edge ok");
        wr2(mk(0, 0, 0, 2'b00, 2'b00, 6'd43), "R7 width at W-s");
        eff(1'b0, 1'b0, 2'b00, 3'd2, 1'b1, "R7 lower edge fault");

        wr2(mk(0, 0, 0, 2'b11, 2'b01, 6'd25), "R4 reserved granule");
        rd2("R4 readback 11");
        eff(1'b0, 1'b0, 2'b00, 3'd1, 1'b0, "R4 acts 4K");

        acc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b1, 3'd0, 1'b1, "R8 EL0 write");
        acc(1'b0, 64'h0, 2'd0, 1'b1, 3'd5, 1'b1, "R8 EL0 read");
        acc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b0, 3'd5, 1'b1, "R8 EL1 nonsecure");
        acc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1'b0, 3'd0, 1'b1, "R8 EL2 nonsecure");
        acc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 3'd0, 1'b0, "R8 EL3 disabled");
        acc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b1, 3'd5, 1'b1, "R9 redirect 101");
        acc(1'b0, 64'h0, 2'd1, 1'b1, 3'd7, 1'b1, "R9 redirect 111");
        acc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b1, 3'd1, 1'b1, "R10 trap 001");
        acc(1'b0, 64'h0, 2'd1, 1'b1, 3'd3, 1'b1, "R10 trap 011");
        acc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b1, 3'd4, 1'b1, "R10 undef 100");
        acc(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b1, 3'd0, 1'b1, "R10 undef 000");
        rd2("R11 word unchanged");
        eff(1'b0, 1'b0, 2'b00, 3'd1, 1'b0, "R11 effective unchanged");

        acc(1'b1, mk(0, 1, 0, 2'b10, 2'b01, 6'd28), 2'd3, 1'b0, 3'd0, 1'b1, "R8 EL3 write");
        acc(1'b0, 64'h0, 2'd3, 1'b0, 3'd0, 1'b1, "R8 EL3 read");
        eff(1'b1, 1'b0, 2'b10, 3'd2, 1'b0, "R8 EL3 write took effect");

        repeat (4) @(negedge clk);
        chk(64'(q_kind.size()), 64'h0, "R12 all responses seen");
        done = 1'b1;
        summary();
        $finish;
    end
endmodule